// File: doc/BRIEF.md
# SECDED-Protected SRAM with Check-Byte Burst Access

This block wraps a word-organised SRAM. Every 32-bit data word is stored together with an 8-bit check byte. The check byte holds an extended Hamming code with minimum distance 4, so the block corrects any single flipped bit and detects any two flipped bits. A request/response slave port drives the block. A two-bit mode input selects one of two behaviours:

- **Normal mode.** Single reads and writes are encoded on the way in and decoded on the way out.
- **Mapping mode** (mode value 2). Only two-beat bursts are accepted. The first beat carries the data word. The second beat carries the raw check byte. This lets software read the code bits directly, or plant chosen errors in them.

Normal reads report a corrected single-bit event or an uncorrectable double-bit event, as a one-cycle pulse alongside the read data. Two enable inputs control the decoder. One turns correction off on its own. The other turns detection off, and correction goes off with it.

A single state machine sequences every access. It has seven states:

- `IDLE` accepts a request.
- `RD_NORM` presents a decoded normal read.
- `RD_DATA` and `RD_CHK` present the two beats of a mapping read.
- `WR_CHK` waits for the second beat of a mapping write.
- `ACK` acknowledges a completed write.
- `FAULT` signals a rejected request.

Transitions:

- `IDLE` goes to `ACK` on a normal write.
- `IDLE` goes to `RD_NORM` on a normal read.
- `IDLE` goes to `WR_CHK` on an aligned mapping write burst.
- `IDLE` goes to `RD_DATA` on an aligned mapping read burst.
- `IDLE` goes to `FAULT` on any other mapping-mode request.
- `WR_CHK` goes to `ACK` when the second beat arrives.
- `RD_DATA` goes to `RD_CHK`.
- `RD_NORM`, `RD_CHK`, `ACK` and `FAULT` return to `IDLE`.

Requests that arrive outside `IDLE` and `WR_CHK` are dropped.

Top module: `ecc_sram`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, ack, bus_err, rvalid, err_single and err_double are 0 and rdata is all zeros.
- R2: In normal mode, a write request (req=1, we=1) stores wdata with a freshly computed check byte, and ack is 1 for exactly the next cycle. A read request (req=1, we=0) gives rvalid=1 with the word in the next cycle. The burst input is ignored.
- R3: Check byte encoding. Number the code positions 1 to 38 and skip the powers of two. Data bit j occupies the j-th remaining position, in ascending order (bit 0 at position 3). Check bit i (i = 0..5) is the XOR of the data bits whose position has bit i set. Bit 6 makes the even parity of the 32 data bits and bits [5:0]. Bit 7 is 0.
- R4: Only mode value 2 selects mapping mode. Values 0, 1 and 3 all give normal single accesses.
- R5: A mapping write burst works as follows. Beat one has req, we and burst at 1 and addr[2:0]=000, and carries the data word. Beat two is the next cycle with req at 1. Its wdata[7:0] is stored verbatim as the check byte, with no re-encoding, and wdata[31:8] is ignored. ack is 1 in the cycle after beat two.
- R6: A mapping read burst (req=1, we=0, burst=1, addr[2:0]=000) gives rvalid=1 for two consecutive cycles, starting in the next cycle. The first beat is the stored data word, uncorrected. The second beat is the stored check byte in bits [7:0], with bits [31:8] at zero.
- R7: In mapping mode, a request with burst=0 or with addr[2:0] not 000 is rejected. bus_err is 1 in the next cycle and rvalid stays 0. The stored data and check byte stay unchanged.
- R8: On a normal read with both enables at 1, a single-bit error is corrected and flagged. A single-bit error means the overall parity fails and the syndrome is 0 or names a position up to 38. The read returns the corrected data, with err_single=1 in the rvalid cycle.
- R9: A double-bit error is one where the overall parity holds but the syndrome is non-zero. On a normal read it returns the raw data, with err_double=1 in the rvalid cycle. err_single and err_double are never 1 together.
- R10: With corr_en=0 and det_en=1, a single-bit error returns the raw data, and err_single is still 1.
- R11: With det_en=0, a normal read returns the raw data, and err_single and err_double stay 0 whatever corr_en is.
- R12: addr is a byte address. In normal mode the word index is addr[IDX+1:2], and addr[1:0] is ignored. In mapping mode the word index is addr[IDX+2:3], so word n sits at 4n in normal mode and at 8n in mapping mode (IDX = log2 DEPTH).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Access mode; 2 selects check-byte mapping |
| corr_en | input | 1 | Enables correction of single-bit errors |
| det_en | input | 1 | Enables error detection and flags |
| req | input | 1 | Request / beat valid |
| we | input | 1 | 1 = write, 0 = read |
| burst | input | 1 | Two-beat burst request (mapping mode) |
| addr | input | ADDR_W | Byte address, ADDR_W = log2(DEPTH)+3 |
| wdata | input | 32 | Write data, or check byte on beat two |
| ack | output | 1 | Write completed |
| bus_err | output | 1 | Request rejected |
| rvalid | output | 1 | Read beat valid on rdata |
| rdata | output | 32 | Read data |
| err_single | output | 1 | Corrected (single-bit) error event |
| err_double | output | 1 | Uncorrectable (double-bit) error event |

## Verification
The assertions rely on two things about the inputs. First, inputs change only between clock edges. Second, the master sends a new request only while the controller is idle. The one exception is beat two of a mapping write, which follows beat one directly. The assertions also assume mode, corr_en and det_en hold steady across the response cycle they affect. The stimulus meets all of this in three ways:

- It drives every input on the falling edge.
- Every transaction leaves one clear cycle before the next request.
- Mode and enables change only between transactions.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;

    // Width of one protected data word.
    localparam int DATA_W = 32;

    // Smallest Hamming check count r with 2**r >= k + r + 1.
    function automatic int ham_bits(input int k);
        for (int r = 1; r < 16; r++) begin
            if ((1 << r) >= k + r + 1) return r;
        end
        return 16;
    endfunction

    localparam int HAM_W  = ham_bits(DATA_W);   // Hamming check bits
    localparam int CODE_N = DATA_W + HAM_W;     // highest code position
    localparam int CHK_W  = 8;                  // stored check byte
    localparam int WORD_W = DATA_W + CHK_W;     // stored word

    localparam logic [1:0] MAP_MODE = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_NORM,
        ST_RD_DATA,
        ST_RD_CHK,
        ST_WR_CHK,
        ST_ACK,
        ST_FAULT
    } state_e;

    // True for code positions that hold Hamming check bits.
    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

endpackage

// File: rtl/ecc_sram_enc.sv
module ecc_sram_enc
    import ecc_sram_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [HAM_W-1:0]  ham_o,
    output logic              par_o
);

    // Each data bit folds its code position into the check vector.
    always_comb begin : fold
        int k;
        k     = 0;
        ham_o = '0;
        for (int p = 1; p <= CODE_N; p++) begin
            if (!is_pow2(p)) begin
                if (data_i[k]) ham_o = ham_o ^ HAM_W'(p);
                k++;
            end
        end
    end

    // Overall parity over data and Hamming bits.
    assign par_o = ^{data_i, ham_o};

endmodule

// File: rtl/ecc_sram_dec.sv
module ecc_sram_dec
    import ecc_sram_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [HAM_W-1:0]  ham_i,
    input  logic              par_i,
    input  logic              corr_en,
    input  logic              det_en,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);

    logic [HAM_W-1:0]  calc_ham;
    logic              calc_par;
    logic [HAM_W-1:0]  syn;
    logic              par_err;
    logic              in_range;
    logic              is_single;
    logic              is_double;
    logic [DATA_W-1:0] fix;

    ecc_sram_enc u_enc (
        .data_i (data_i),
        .ham_o  (calc_ham),
        .par_o  (calc_par)
    );

    assign syn = calc_ham ^ ham_i;
    // Parity of every stored bit, rebuilt from the recomputed parity.
    assign par_err   = calc_par ^ par_i ^ (^syn);
    assign in_range  = int'(syn) <= CODE_N;
    assign is_single = par_err && in_range;
    assign is_double = (!par_err && (syn != '0)) || (par_err && !in_range);

    // The syndrome names the flipped position; map it back to a data bit.
    always_comb begin : locate
        int k;
        k   = 0;
        fix = '0;
        for (int p = 1; p <= CODE_N; p++) begin
            if (!is_pow2(p)) begin
                if (syn == HAM_W'(p)) fix[k] = 1'b1;
                k++;
            end
        end
    end

    assign single_o = det_en && is_single;
    assign double_o = det_en && is_double;
    assign data_o   = (det_en && corr_en && is_single) ? (data_i ^ fix) : data_i;

endmodule

// File: rtl/ecc_sram_array.sv
module ecc_sram_array
    import ecc_sram_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] wword_i,
    output logic [WORD_W-1:0] rword_o
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Single port, registered read; the read word holds until the next read.
    always_ff @(posedge clk) begin
        if (we_i) mem[idx_i] <= wword_i;
        if (re_i) rword_o    <= mem[idx_i];
    end

endmodule

// File: rtl/ecc_sram.sv
module ecc_sram
    import ecc_sram_pkg::*;
#(
    parameter  int DEPTH  = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              corr_en,
    input  logic              det_en,
    input  logic              req,
    input  logic              we,
    input  logic              burst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic              bus_err,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic              err_single,
    output logic              err_double
);

    state_e            state;
    state_e            nxt;

    logic              is_map;
    logic              aligned;
    logic [IDX_W-1:0]  idx_norm;
    logic [IDX_W-1:0]  idx_map;

    logic [DATA_W-1:0] hold_data;
    logic [IDX_W-1:0]  hold_idx;

    logic              mem_we;
    logic              mem_re;
    logic [IDX_W-1:0]  mem_idx;
    logic [WORD_W-1:0] mem_wword;
    logic [WORD_W-1:0] rword;

    logic [HAM_W-1:0]  enc_ham;
    logic              enc_par;
    logic [CHK_W-1:0]  enc_chk;

    logic [DATA_W-1:0] dec_data;
    logic              dec_single;
    logic              dec_double;

    // Request decode
    assign is_map   = (mode == MAP_MODE);
    assign aligned  = (addr[2:0] == 3'b000);
    assign idx_norm = addr[IDX_W+1:2];
    assign idx_map  = addr[IDX_W+2:3];

    // Datapath: write encoder, storage, read decoder
    ecc_sram_enc u_enc (
        .data_i (wdata),
        .ham_o  (enc_ham),
        .par_o  (enc_par)
    );

    assign enc_chk = CHK_W'({enc_par, enc_ham});

    ecc_sram_array #(.DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .we_i    (mem_we),
        .re_i    (mem_re),
        .idx_i   (mem_idx),
        .wword_i (mem_wword),
        .rword_o (rword)
    );

    ecc_sram_dec u_dec (
        .data_i   (rword[DATA_W-1:0]),
        .ham_i    (rword[DATA_W+HAM_W-1:DATA_W]),
        .par_i    (rword[DATA_W+HAM_W]),
        .corr_en  (corr_en),
        .det_en   (det_en),
        .data_o   (dec_data),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Beat-one capture of a check-byte write burst
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_idx  <= '0;
        end else if (state == ST_IDLE && nxt == ST_WR_CHK) begin
            hold_data <= wdata;
            hold_idx  <= idx_map;
        end
    end

    // Transitions and memory strobes
    always_comb begin
        nxt       = state;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_idx   = idx_norm;
        mem_wword = {enc_chk, wdata};
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    if (!is_map) begin
                        if (we) begin
                            mem_we = 1'b1;
                            nxt    = ST_ACK;
                        end else begin
                            mem_re = 1'b1;
                            nxt    = ST_RD_NORM;
                        end
                    end else if (!burst || !aligned) begin
                        nxt = ST_FAULT;
                    end else if (we) begin
                        nxt = ST_WR_CHK;
                    end else begin
                        mem_idx = idx_map;
                        mem_re  = 1'b1;
                        nxt     = ST_RD_DATA;
                    end
                end
            end
            ST_WR_CHK: begin
                if (req) begin
                    mem_idx   = hold_idx;
                    mem_wword = {wdata[CHK_W-1:0], hold_data};
                    mem_we    = 1'b1;
                    nxt       = ST_ACK;
                end
            end
            ST_RD_DATA: nxt = ST_RD_CHK;
            ST_RD_NORM,
            ST_RD_CHK,
            ST_ACK,
            ST_FAULT:   nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Bus outputs
    always_comb begin
        ack        = 1'b0;
        bus_err    = 1'b0;
        rvalid     = 1'b0;
        rdata      = '0;
        err_single = 1'b0;
        err_double = 1'b0;
        unique case (state)
            ST_RD_NORM: begin
                rvalid     = 1'b1;
                rdata      = dec_data;
                err_single = dec_single;
                err_double = dec_double;
            end
            ST_RD_DATA: begin
                rvalid = 1'b1;
                rdata  = rword[DATA_W-1:0];
            end
            ST_RD_CHK: begin
                rvalid = 1'b1;
                rdata  = DATA_W'(rword[WORD_W-1:DATA_W]);
            end
            ST_ACK:   ack     = 1'b1;
            ST_FAULT: bus_err = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ecc_sram_chk.sv
module ecc_sram_chk
    import ecc_sram_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              det_en,
    input logic              req,
    input logic              we,
    input logic              burst,
    input logic [ADDR_W-1:0] addr,
    input logic              ack,
    input logic              bus_err,
    input logic              rvalid,
    input logic [DATA_W-1:0] rdata,
    input logic              err_single,
    input logic              err_double,
    input state_e            state,
    input logic              mem_we
);

    // R1
    resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack, bus_err, rvalid}));

    // R2
    wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req && we && mode != MAP_MODE) |=> ack);

    // R2
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req && !we && mode != MAP_MODE) |=> rvalid);

    // R6
    map_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req && !we && burst && addr[2:0] == 3'b000 && mode == MAP_MODE)
        |=> (rvalid ##1 (rvalid && rdata[DATA_W-1:8] == '0)));

    // R7
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req && mode == MAP_MODE && (!burst || addr[2:0] != 3'b000))
        |-> (!mem_we ##1 (bus_err && !rvalid)));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_single || err_double) |-> (rvalid && !(err_single && err_double)));

    // R11
    det_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |-> (!err_single && !err_double));

endmodule

bind ecc_sram ecc_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .det_en     (det_en),
    .req        (req),
    .we         (we),
    .burst      (burst),
    .addr       (addr),
    .ack        (ack),
    .bus_err    (bus_err),
    .rvalid     (rvalid),
    .rdata      (rdata),
    .err_single (err_single),
    .err_double (err_double),
    .state      (state),
    .mem_we     (mem_we)
);

// File: tb/ecc_sram_test.sv
module ecc_sram_test;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int AW     = 7;
    localparam int NV     = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode;
    logic          corr_en, det_en, req, we, burst;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic          ack, bus_err, rvalid, err_single, err_double;
    logic [31:0]   rdata;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    ecc_sram #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .corr_en(corr_en), .det_en(det_en),
        .req(req), .we(we), .burst(burst), .addr(addr), .wdata(wdata),
        .ack(ack), .bus_err(bus_err), .rvalid(rvalid), .rdata(rdata),
        .err_single(err_single), .err_double(err_double)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [31:0] data;
        logic [31:0] dflip;
        logic [7:0]  cflip;
        logic        corr;
        logic        det;
        logic [31:0] expd;
        logic        exps;
        logic        expdbl;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{32'hA5A55A5A, 32'h00000000, 8'h00, 1'b1, 1'b1, 32'hA5A55A5A, 1'b0, 1'b0},
        '{32'h12345678, 32'h00000001, 8'h00, 1'b1, 1'b1, 32'h12345678, 1'b1, 1'b0},
        '{32'h12345678, 32'h80000000, 8'h00, 1'b1, 1'b1, 32'h12345678, 1'b1, 1'b0},
        '{32'h12345678, 32'h00000000, 8'h04, 1'b1, 1'b1, 32'h12345678, 1'b1, 1'b0},
        '{32'h12345678, 32'h00000000, 8'h40, 1'b1, 1'b1, 32'h12345678, 1'b1, 1'b0},
        '{32'h12345678, 32'h00020008, 8'h00, 1'b1, 1'b1, 32'h12365670, 1'b0, 1'b1},
        '{32'h12345678, 32'h00000020, 8'h01, 1'b1, 1'b1, 32'h12345658, 1'b0, 1'b1},
        '{32'h12345678, 32'h00000200, 8'h00, 1'b0, 1'b1, 32'h12345478, 1'b1, 1'b0},
        '{32'h12345678, 32'h00000600, 8'h00, 1'b1, 1'b0, 32'h12345078, 1'b0, 1'b0},
        '{32'h12345678, 32'h00000002, 8'h00, 1'b1, 1'b0, 32'h1234567A, 1'b0, 1'b0},
        '{32'hFFFFFFFF, 32'h00000000, 8'h03, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b1},
        '{32'h00000000, 32'h00000000, 8'h00, 1'b1, 1'b1, 32'h00000000, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Check byte computed from the R3 encoding rule.
    function automatic logic [7:0] ref_chk(input logic [31:0] d);
        logic [5:0] h;
        int k;
        h = '0;
        k = 0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[k]) h = h ^ p[5:0];
                k++;
            end
        end
        return {1'b0, ^{d, h}, h};
    endfunction

    // Every task starts and ends at a falling edge with the controller idle.
    task automatic nwrite(input logic [AW-1:0] a, input logic [31:0] d, output logic ak);
        req = 1'b1; we = 1'b1; burst = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        ak = ack;
        req = 1'b0; we = 1'b0;
        @(negedge clk);
    endtask

    task automatic nread(input logic [AW-1:0] a, output logic [31:0] d,
                         output logic v, output logic s, output logic db);
        req = 1'b1; we = 1'b0; burst = 1'b0; addr = a;
        @(negedge clk);
        d = rdata; v = rvalid; s = err_single; db = err_double;
        req = 1'b0;
        @(negedge clk);
    endtask

    task automatic mwrite(input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [31:0] beat2, output logic ak);
        req = 1'b1; we = 1'b1; burst = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wdata = beat2;
        @(negedge clk);
        ak = ack;
        req = 1'b0; we = 1'b0; burst = 1'b0;
        @(negedge clk);
    endtask

    task automatic mread(input logic [AW-1:0] a, output logic [31:0] d, output logic [31:0] c,
                         output logic v1, output logic v2);
        req = 1'b1; we = 1'b0; burst = 1'b1; addr = a;
        @(negedge clk);
        d = rdata; v1 = rvalid;
        req = 1'b0; burst = 1'b0;
        @(negedge clk);
        c = rdata; v2 = rvalid;
        @(negedge clk);
    endtask

    task automatic reject(input logic [AW-1:0] a, input logic w, input logic b,
                          output logic be, output logic rv);
        req = 1'b1; we = w; burst = b; addr = a; wdata = 32'h0;
        @(negedge clk);
        be = bus_err; rv = rvalid;
        req = 1'b0; we = 1'b0; burst = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d, c;
        logic ak, v, v2, s, db, be;

        rst_n = 1'b0; mode = 2'd0; corr_en = 1'b1; det_en = 1'b1;
        req = 1'b0; we = 1'b0; burst = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        check("R1 ack in reset", {31'b0, ack}, 32'd0);
        check("R1 rvalid in reset", {31'b0, rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack", {31'b0, ack}, 32'd0);
        check("R1 bus_err", {31'b0, bus_err}, 32'd0);
        check("R1 rvalid", {31'b0, rvalid}, 32'd0);
        check("R1 flags", {30'b0, err_single, err_double}, 32'd0);
        check("R1 rdata", rdata, 32'd0);

        // Vector table: write, inspect check byte, inject, decode.
        for (int i = 0; i < NV; i++) begin
            vec_t vv;
            string tag;
            logic [7:0] good;
            vv   = VECS[i];
            good = ref_chk(vv.data);
            if (!vv.det)                      tag = "R11";
            else if (!vv.corr)                tag = "R10";
            else if (vv.expdbl)               tag = "R9";
            else if (vv.exps)                 tag = "R8";
            else                              tag = "R2";

            mode = 2'd0;
            nwrite(AW'(i * 4), vv.data, ak);
            check("R2 write ack", {31'b0, ak}, 32'd1);

            mode = 2'd2;
            mread(AW'(i * 8), d, c, v, v2);
            check("R6 both beats valid", {30'b0, v, v2}, 32'd3);
            check("R6 beat one data", d, vv.data);
            check("R3 stored check byte", c, {24'b0, good});

            mwrite(AW'(i * 8), vv.data ^ vv.dflip, {24'hB71E94, good ^ vv.cflip}, ak);
            check("R5 burst write ack", {31'b0, ak}, 32'd1);
            mread(AW'(i * 8), d, c, v, v2);
            check("R6 raw beat one after injection", d, vv.data ^ vv.dflip);
            check("R5 check byte verbatim, upper ignored", c, {24'b0, good ^ vv.cflip});

            mode = 2'd0; corr_en = vv.corr; det_en = vv.det;
            nread(AW'(i * 4), d, v, s, db);
            check({tag, " rvalid"}, {31'b0, v}, 32'd1);
            check({tag, " read data"}, d, vv.expd);
            check({tag, " err_single"}, {31'b0, s}, {31'b0, vv.exps});
            check({tag, " err_double"}, {31'b0, db}, {31'b0, vv.expdbl});
            corr_en = 1'b1; det_en = 1'b1;
        end

        // R4: modes 1 and 3 are normal single accesses.
        mode = 2'd3;
        nwrite(AW'(12 * 4), 32'h0BADBEEF, ak);
        check("R4 mode 3 write ack", {31'b0, ak}, 32'd1);
        mode = 2'd1;
        nread(AW'(12 * 4), d, v, s, db);
        check("R4 mode 1 read data", d, 32'h0BADBEEF);
        check("R4 mode 1 read valid, no flags", {29'b0, v, s, db}, 32'd4);

        // R12: normal address low bits ignored; mapping index from addr[6:3].
        mode = 2'd0;
        nwrite(AW'(13 * 4 + 3), 32'h600DF00D, ak);
        nread(AW'(13 * 4), d, v, s, db);
        check("R12 addr[1:0] ignored", d, 32'h600DF00D);
        mode = 2'd2;
        mwrite(AW'(14 * 8), 32'h13579BDF, {24'h0, ref_chk(32'h13579BDF)}, ak);
        mode = 2'd0;
        nread(AW'(14 * 4), d, v, s, db);
        check("R12 mapping word 14 seen at 56", d, 32'h13579BDF);
        check("R12 clean code, no flags", {30'b0, s, db}, 32'd0);

        // R7: rejected mapping requests leave word 13 untouched.
        mode = 2'd2;
        reject(AW'(13 * 8), 1'b1, 1'b0, be, v);
        check("R7 single write rejected", {30'b0, be, v}, 32'd2);
        reject(AW'(13 * 8 + 4), 1'b1, 1'b1, be, v);
        check("R7 misaligned burst write rejected", {30'b0, be, v}, 32'd2);
        reject(AW'(13 * 8 + 1), 1'b0, 1'b1, be, v);
        check("R7 misaligned burst read rejected", {30'b0, be, v}, 32'd2);
        reject(AW'(13 * 8), 1'b0, 1'b0, be, v);
        check("R7 single read rejected", {30'b0, be, v}, 32'd2);
        mread(AW'(13 * 8), d, c, v, v2);
        check("R7 data unchanged", d, 32'h600DF00D);
        check("R7 check byte unchanged", c, {24'b0, ref_chk(32'h600DF00D)});
        mode = 2'd0;
        nread(AW'(13 * 4), d, v, s, db);
        check("R7 normal read unchanged", d, 32'h600DF00D);
        check("R7 no flags after rejects", {30'b0, s, db}, 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule